// File: doc/BRIEF.md
# Selectable Binary Line Encoder

This block turns a serial stream of data bits into a line level code, using one of seven line codes chosen by a scheme select. Time on the line is divided into half-bit slots that an external `tick` strobe marks. Each data bit takes two consecutive slots. This lets the block express codes that change level in the middle of a bit, such as Manchester and return-to-zero, as well as codes that hold one level for the whole bit. The output is a 2-bit signed level code: zero, positive or negative.

A source presents a bit with `bit_valid` and holds it until `accept` pulses. `accept` can only pulse on a tick that falls on a bit boundary, so at most one bit is taken every two ticks. The scheme select is read only when a bit is taken. If it differs from the scheme in use, the memory that scheme needs is put back to its start state before that bit is coded. This memory is the last line polarity for NRZ-I and differential Manchester, and the next mark polarity for AMI and pseudoternary.

The bit timer is a three-state machine. PH_IDLE means no bit is on the line. PH_FIRST means the first half of a bit is being driven. PH_SECOND means the second half is being driven. The machine moves as follows:
- PH_IDLE to PH_FIRST, and PH_SECOND to PH_FIRST, on a tick with `bit_valid` high (a load).
- PH_IDLE to PH_IDLE, and PH_SECOND to PH_IDLE, on a tick with `bit_valid` low (a rest).
- PH_FIRST to PH_SECOND on any tick (the mid-bit step).
- Without a tick, every state holds.

Top module: `line_encoder`

## Requirements
- R1: Level codes are 2'b00 zero, 2'b01 positive and 2'b11 negative, and 2'b10 never appears. After reset the output is negative, `accept` is low, the scheme in use is NRZ-L, the line polarity memory is negative and the next mark is positive.
- R2: The output changes only on the clock edge where `tick` is high. `accept` equals `tick` and `bit_valid` together outside the first half of a bit. A loaded bit's first half shows after its load tick, and its second half shows after the next tick.
- R3: NRZ-L (scheme 3'd0) drives positive for a 0 and negative for a 1, in both halves.
- R4: NRZ-I (scheme 3'd1) inverts the stored polarity for a 1 and keeps it for a 0. The result is driven in both halves.
- R5: Polar RZ (scheme 3'd2) drives positive for a 1 and negative for a 0 in the first half, then zero in the second half.
- R6: Manchester (scheme 3'd3) drives positive then negative for a 0, and negative then positive for a 1.
- R7: Differential Manchester (scheme 3'd4) starts a 0 at the opposite of the last half-level and starts a 1 at the same level. Its second half is always the inverse of its first half.
- R8: AMI (scheme 3'd5) drives zero for a 0. Each 1 drives the mark polarity for the whole bit, and the mark polarity then flips.
- R9: Pseudoternary (scheme 3'd6) drives zero for a 1. Each 0 drives the mark polarity for the whole bit, and the mark polarity then flips.
- R10: A load whose scheme differs from the one in use restarts the memory: line polarity negative, next mark positive. A load with the same scheme keeps the memory. `scheme_sel` has no effect during the second half of a bit.
- R11: On a rest tick the line holds its level under NRZ-L and NRZ-I, and goes to zero under every other scheme. Scheme 3'd7 drives zero in both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Half-bit slot strobe, one clock wide |
| bit_valid | input | 1 | A data bit is offered |
| bit_in | input | 1 | Data bit |
| scheme_sel | input | 3 | Line code select, read on a load |
| accept | output | 1 | The offered bit is taken on this clock |
| level | output | 2 | Line level code |

## Verification
Every scheme is driven with random bits, with runs of sixteen 1s, with runs of sixteen 0s, and with alternating bits. The runs of one value show whether the NRZ-I, AMI and pseudoternary memories invert at the right bits. The alternating bits show whether each start and mid-bit level follows the data. The schemes are visited twice in order and then once more with repeats, so that both a restarted memory and a kept memory are compared with the reference. Rest ticks after each pattern, and a select changed during the second half of a bit, check the idle levels and that a mid-bit select has no effect.

// File: rtl/le_pkg.sv
package le_pkg;

    localparam int LVL_W = 2;
    localparam int SCH_W = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } level_e;

    typedef enum logic [SCH_W-1:0] {
        SCH_NRZL   = 3'd0,
        SCH_NRZI   = 3'd1,
        SCH_RZ     = 3'd2,
        SCH_MAN    = 3'd3,
        SCH_DMAN   = 3'd4,
        SCH_AMI    = 3'd5,
        SCH_PSEUDO = 3'd6,
        SCH_OFF    = 3'd7
    } scheme_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    typedef struct packed {
        logic line_pos;   // last polarity / half-level was positive
        logic mark_pos;   // next mark pulse is positive
    } mem_t;

    localparam mem_t MEM_INIT = '{line_pos: 1'b0, mark_pos: 1'b1};

    function automatic level_e pol_level(input logic pos);
        return pos ? LVL_POS : LVL_NEG;
    endfunction

endpackage

// File: rtl/le_half_timer.sv
module le_half_timer
    import le_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   bit_valid,
    output phase_e phase,
    output logic   load,
    output logic   mid,
    output logic   rest
);

    phase_e phase_q, phase_d;
    logic   boundary;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE, PH_SECOND: begin
                if (tick) phase_d = bit_valid ? PH_FIRST : PH_IDLE;
            end
            PH_FIRST: begin
                if (tick) phase_d = PH_SECOND;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_comb begin
        boundary = (phase_q != PH_FIRST);
        load     = tick &  bit_valid & boundary;
        rest     = tick & ~bit_valid & boundary;
        mid      = tick & ~boundary;
        phase    = phase_q;
    end

endmodule

// File: rtl/le_symbol_map.sv
module le_symbol_map
    import le_pkg::*;
(
    input  scheme_e scheme,
    input  logic    data,
    input  mem_t    mem,
    output level_e  first_lvl,
    output level_e  second_lvl,
    output mem_t    mem_next
);

    logic start_pos;

    always_comb begin
        mem_next   = mem;
        first_lvl  = LVL_ZERO;
        second_lvl = LVL_ZERO;
        start_pos  = 1'b0;
        unique case (scheme)
            SCH_NRZL: begin
                first_lvl  = data ? LVL_NEG : LVL_POS;
                second_lvl = first_lvl;
            end
            SCH_NRZI: begin
                start_pos         = mem.line_pos ^ data;
                first_lvl         = pol_level(start_pos);
                second_lvl        = first_lvl;
                mem_next.line_pos = start_pos;
            end
            SCH_RZ: begin
                first_lvl  = data ? LVL_POS : LVL_NEG;
                second_lvl = LVL_ZERO;
            end
            SCH_MAN: begin
                first_lvl  = data ? LVL_NEG : LVL_POS;
                second_lvl = data ? LVL_POS : LVL_NEG;
            end
            SCH_DMAN: begin
                start_pos         = data ? mem.line_pos : ~mem.line_pos;
                first_lvl         = pol_level(start_pos);
                second_lvl        = pol_level(~start_pos);
                mem_next.line_pos = ~start_pos;
            end
            SCH_AMI, SCH_PSEUDO: begin
                if (data == (scheme == SCH_AMI)) begin
                    first_lvl         = pol_level(mem.mark_pos);
                    second_lvl        = first_lvl;
                    mem_next.mark_pos = ~mem.mark_pos;
                end
            end
            SCH_OFF: begin
                first_lvl  = LVL_ZERO;
                second_lvl = LVL_ZERO;
            end
            default: begin
                first_lvl  = LVL_ZERO;
                second_lvl = LVL_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/line_encoder.sv
module line_encoder
    import le_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic [SCH_W-1:0] scheme_sel,
    output logic             accept,
    output logic [LVL_W-1:0] level
);

    phase_e  phase_q;
    logic    load, mid, rest;
    scheme_e scheme_q;
    mem_t    mem_q, work_mem, mem_next;
    level_e  level_q, second_q, first_lvl, second_lvl;
    logic    holds_on_rest;

    le_half_timer timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bit_valid (bit_valid),
        .phase     (phase_q),
        .load      (load),
        .mid       (mid),
        .rest      (rest)
    );

    assign work_mem = (scheme_sel != scheme_q) ? MEM_INIT : mem_q;

    le_symbol_map map_i (
        .scheme     (scheme_e'(scheme_sel)),
        .data       (bit_in),
        .mem        (work_mem),
        .first_lvl  (first_lvl),
        .second_lvl (second_lvl),
        .mem_next   (mem_next)
    );

    assign holds_on_rest = (scheme_q == SCH_NRZL) || (scheme_q == SCH_NRZI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scheme_q <= SCH_NRZL;
            mem_q    <= MEM_INIT;
            level_q  <= LVL_NEG;
            second_q <= LVL_NEG;
        end else if (load) begin
            scheme_q <= scheme_e'(scheme_sel);
            mem_q    <= mem_next;
            level_q  <= first_lvl;
            second_q <= second_lvl;
        end else if (mid) begin
            level_q  <= second_q;
        end else if (rest && !holds_on_rest) begin
            level_q  <= LVL_ZERO;
        end
    end

    assign accept = load;
    assign level  = level_q;

endmodule

// File: rtl/le_checker.sv
module le_checker
    import le_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             accept,
    input logic [LVL_W-1:0] level,
    input phase_e           phase,
    input scheme_e          scheme
);

    AST_LEVEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        level != 2'b10); // R1

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level)); // R2

    AST_ACCEPT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (tick && phase != PH_FIRST)); // R2

    AST_NRZL_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == PH_FIRST && scheme == SCH_NRZL) |=> $stable(level)); // R3

    AST_RZ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == PH_FIRST && scheme == SCH_RZ) |=> level == LVL_ZERO); // R5

    AST_MAN_MID_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == PH_FIRST && scheme == SCH_MAN) |=> level != $past(level)); // R6

    AST_DMAN_MID_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && phase == PH_FIRST && scheme == SCH_DMAN) |=> level != $past(level)); // R7

endmodule

bind line_encoder le_checker chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .accept (accept),
    .level  (level),
    .phase  (phase_q),
    .scheme (scheme_q)
);

// File: tb/line_encoder_tb_top.sv
module line_encoder_tb_top;

    localparam logic [1:0] ZERO = 2'b00;
    localparam logic [1:0] POS  = 2'b01;
    localparam logic [1:0] NEG  = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic [2:0] scheme_sel = 3'd0;
    logic       accept;
    logic [1:0] level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       ref_line = 1'b0;
    logic       ref_mark = 1'b1;
    logic [2:0] ref_sch = 3'd0;
    logic [1:0] ref_out = NEG;
    logic       seen_acc;

    always #10 clk = ~clk;

    line_encoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .scheme_sel (scheme_sel),
        .accept     (accept),
        .level      (level)
    );

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [1:0] sgn(input int v);
        return (v > 0) ? POS : (v < 0) ? NEG : ZERO;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        #1 seen_acc = accept;
        @(negedge clk);
        tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [2:0] sch, input logic b);
        int e1, e2;
        logic start;
        if (sch != ref_sch) begin
            ref_line = 1'b0;
            ref_mark = 1'b1;
            ref_sch  = sch;
        end
        e1 = 0; e2 = 0;
        case (sch)
            3'd0: begin e1 = b ? -1 : 1; e2 = e1; end
            3'd1: begin ref_line = ref_line ^ b; e1 = ref_line ? 1 : -1; e2 = e1; end
            3'd2: begin e1 = b ? 1 : -1; e2 = 0; end
            3'd3: begin e1 = b ? -1 : 1; e2 = -e1; end
            3'd4: begin
                start = b ? ref_line : !ref_line;
                e1 = start ? 1 : -1; e2 = -e1; ref_line = !start;
            end
            3'd5, 3'd6: begin
                if (b == (sch == 3'd5)) begin
                    e1 = ref_mark ? 1 : -1; e2 = e1; ref_mark = !ref_mark;
                end
            end
            default: begin e1 = 0; e2 = 0; end
        endcase
        bit_in = b;
        scheme_sel = sch;
        bit_valid = 1'b1;
        pulse_tick();
        check("R2", {1'b0, seen_acc}, 2'b01);
        check(tag_of(sch), level, sgn(e1));
        bit_valid = 1'b1;               // offered during second half: must not be taken
        scheme_sel = sch ^ 3'd5;        // R10: select change mid-bit has no effect
        pulse_tick();
        check("R2", {1'b0, seen_acc}, 2'b00);
        check(tag_of(sch), level, sgn(e2));
        bit_valid = 1'b0;
        scheme_sel = sch;
        ref_out = sgn(e2);
    endtask

    task automatic rest_tick();
        logic [1:0] exp;
        bit_valid = 1'b0;
        exp = (ref_sch <= 3'd1) ? ref_out : ZERO;
        pulse_tick();
        check("R11", level, exp);
        ref_out = exp;
    endtask

    task automatic pattern_set(input logic [2:0] sch);
        for (int i = 0; i < 16; i++) send(sch, 1'($urandom));
        for (int i = 0; i < 16; i++) send(sch, 1'b1);
        for (int i = 0; i < 16; i++) send(sch, 1'b0);
        for (int i = 0; i < 8; i++)  send(sch, 1'(i));
        rest_tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", level, NEG);
        check("R1", {1'b0, accept}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: no tick, valid high: nothing taken, level unchanged
        bit_valid = 1'b1;
        repeat (5) @(negedge clk);
        check("R2", level, NEG);
        check("R2", {1'b0, accept}, 2'b00);
        bit_valid = 1'b0;
        rest_tick();
        // R1: first AMI mark after reset is positive
        send(3'd5, 1'b1);
        for (int r = 0; r < 2; r++)
            for (int s = 0; s < 8; s++) pattern_set(3'(s));
        // R10: same scheme kept across a rest keeps its memory
        for (int s = 1; s < 7; s++) begin
            pattern_set(3'(s));
            pattern_set(3'(s));
        end
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule